// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line-Break Detection

This block receives asynchronous serial characters on a single line. It samples the line on a tick enable that runs at sixteen times the bit rate. Each character arrives least significant bit first and has a low start bit, a configurable number of data bits, an optional parity bit, and one stop bit. The line input passes through a two-flop synchronizer before any sampling. A low level is accepted as a start bit only if it is still low at tick 8 of that bit. Every later bit is sampled once, sixteen ticks after the previous sample, which places each sample at the middle of its bit.

A frame in which the data bits, the parity bit (when enabled) and the stop bit are all low is not treated as a framing error. It is treated as a line break. The receiver sets a sticky break flag, produces no character, and waits for the line to come back high. The return of the line counts as the end of the break once the line has been high for two consecutive ticks. That event sets the break flag again, and the receiver then looks for a new start bit. The break flag holds its value until the status-clear strobe is pulsed.

Top module: `uart_brk_rx`

## Requirements
- R1: A frame with a high stop bit delivers its data bits, least significant bit first, on `rx_data` with a one-cycle `rx_valid` pulse, and `frame_err` is 0.
- R2: With parity enabled (even by default), a parity bit that does not make the count of ones in data plus parity even sets `parity_err` together with `rx_valid`. A correct parity bit leaves `parity_err` at 0.
- R3: A frame with a low stop bit whose data bits or parity bit contain a 1 is delivered with `rx_valid` and `frame_err` set to 1, and `brk_flag` is left unchanged.
- R4: A frame with all data bits, the parity bit and the stop bit sampled low sets `brk_flag`, forces `frame_err` and `parity_err` to 0, and produces no `rx_valid` pulse.
- R5: After a break, the line counts as returned only after it has been sampled high on 2 consecutive ticks, and this event sets `brk_flag`. A high level seen on a single tick does not.
- R6: `brk_flag` stays set until `clr_status` is pulsed. A pulse clears it when no set event happens in the same cycle.
- R7: A low level that is high again at tick 8 after it was first seen is rejected as a false start, and no character is produced.
- R8: After the end of a break, the receiver returns to idle and receives the next frame correctly.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling enable, sixteen pulses per bit |
| rxd | input | 1 | Serial line, idles high |
| clr_status | input | 1 | Strobe that clears the break flag |
| rx_data | output | DATA_BITS | Last received character |
| rx_valid | output | 1 | One-cycle pulse when a character is delivered |
| frame_err | output | 1 | Stop bit was low on the last delivered character |
| parity_err | output | 1 | Parity mismatch on the last delivered character |
| brk_flag | output | 1 | Sticky flag for break start and break end |

## Verification
The receive path is exercised with several kinds of frame: clean frames carrying varied data and correct parity, a frame with a deliberately wrong parity bit, low-stop frames whose payload is non-zero, and an all-zero frame with a low stop bit. Comparing the zero-data/high-parity low-stop frame with the true all-zero frame separates the framing-error case from the break case. A one-tick high glitch during a break, set against a sustained high level, checks the two-tick threshold for the end of a break. A short low pulse that rises again before tick 8 checks that false starts are rejected. A clean frame sent after the break shows that the receiver is back in idle.

// File: rtl/uart_brk_rx.sv
module uart_brk_rx #(
  parameter int DATA_BITS  = 8,
  parameter int PARITY_EN  = 1,
  parameter int PARITY_ODD = 0,
  parameter int OSR        = 16,
  parameter int END_TICKS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rxd,
  input  logic                 clr_status,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 frame_err,
  output logic                 parity_err,
  output logic                 brk_flag
);
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] MID_M1 = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] BIT_M1 = CW'(OSR - 1);
  localparam logic [CW-1:0] END_M1 = CW'(END_TICKS - 1);
  localparam logic [IW-1:0] LAST   = IW'(DATA_BITS - 1);
  localparam logic          ODD    = (PARITY_ODD != 0);
  localparam logic          HASPAR = (PARITY_EN != 0);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;

  st_t                 state;
  logic [1:0]          sync;
  logic [CW-1:0]       cnt;
  logic [IW-1:0]       idx;
  logic [DATA_BITS-1:0] shreg;
  logic                pbit;

  wire rxd_s    = sync[1];
  wire bit_end  = (cnt == BIT_M1);
  wire perr     = HASPAR && ((^shreg ^ pbit) != ODD);
  wire brk_cand = (shreg == '0) && (!HASPAR || !pbit);

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      idx        <= '0;
      shreg      <= '0;
      pbit       <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
      brk_flag   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (clr_status) brk_flag <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE:
            if (!rxd_s) begin
              state <= S_START;
              cnt   <= CW'(1);
            end
          S_START:
            if (cnt == MID_M1) begin
              cnt <= '0;
              idx <= '0;
              state <= rxd_s ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          S_DATA:
            if (bit_end) begin
              cnt   <= '0;
              shreg <= {rxd_s, shreg[DATA_BITS-1:1]};
              idx   <= idx + 1'b1;
              if (idx == LAST) state <= HASPAR ? S_PAR : S_STOP;
            end else cnt <= cnt + 1'b1;
          S_PAR:
            if (bit_end) begin
              cnt   <= '0;
              pbit  <= rxd_s;
              state <= S_STOP;
            end else cnt <= cnt + 1'b1;
          S_STOP:
            if (bit_end) begin
              cnt <= '0;
              if (!rxd_s && brk_cand) begin
                brk_flag   <= 1'b1;
                frame_err  <= 1'b0;
                parity_err <= 1'b0;
                state      <= S_BRK;
              end else begin
                rx_valid   <= 1'b1;
                rx_data    <= shreg;
                frame_err  <= !rxd_s;
                parity_err <= perr;
                state      <= S_IDLE;
              end
            end else cnt <= cnt + 1'b1;
          S_BRK:
            if (!rxd_s) cnt <= '0;
            else if (cnt == END_M1) begin
              cnt      <= '0;
              brk_flag <= 1'b1;
              state    <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_valid_from_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(state) == S_STOP);

  p_break_no_char_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && state == S_STOP && bit_end && !rxd_s && brk_cand)
      |=> brk_flag && !frame_err && !rx_valid && state == S_BRK);

  p_break_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BRK && tick && rxd_s && cnt == END_M1) |=> brk_flag && state == S_IDLE);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !clr_status) |=> brk_flag);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !(tick && (state == S_STOP || state == S_BRK))) |=> !brk_flag);

  p_brk_leaves_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && frame_err) |-> $stable(brk_flag) || $fell(brk_flag));
endmodule

// File: tb/sim_uart_brk_rx.sv
module sim_uart_brk_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rxd = 1'b1;
  logic clr_status = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, frame_err, parity_err, brk_flag;

  int checks = 0;
  int fails = 0;
  int nvalid = 0;
  logic [7:0] last_d = 8'h00;
  logic last_fe = 1'b0;
  logic last_pe = 1'b0;
  logic [1:0] tdiv = 2'd0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  uart_brk_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .clr_status(clr_status),
    .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
    .parity_err(parity_err), .brk_flag(brk_flag)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      nvalid  <= nvalid + 1;
      last_d  <= rx_data;
      last_fe <= frame_err;
      last_pe <= parity_err;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic p, input logic s, input int stop_ticks);
    rxd = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      wait_ticks(16);
    end
    rxd = p;
    wait_ticks(16);
    rxd = s;
    wait_ticks(stop_ticks);
  endtask

  task automatic t_reset;
    check("R9 rx_valid", rx_valid, 0);
    check("R9 rx_data", rx_data, 0);
    check("R9 frame_err", frame_err, 0);
    check("R9 parity_err", parity_err, 0);
    check("R9 brk_flag", brk_flag, 0);
  endtask

  task automatic t_good(input logic [7:0] d);
    int n0 = nvalid;
    send_frame(d, ^d, 1'b1, 16);
    wait_ticks(32);
    check("R1 valid count", nvalid, n0 + 1);
    check("R1 data", last_d, d);
    check("R1 frame_err", last_fe, 0);
    check("R2 parity ok", last_pe, 0);
  endtask

  task automatic t_bad_parity;
    int n0 = nvalid;
    send_frame(8'h5A, 1'b1, 1'b1, 16);
    wait_ticks(32);
    check("R2 valid count", nvalid, n0 + 1);
    check("R2 data", last_d, 8'h5A);
    check("R2 parity_err", last_pe, 1);
  endtask

  task automatic t_frame_err(input logic [7:0] d, input logic p);
    int n0 = nvalid;
    send_frame(d, p, 1'b0, 12);
    rxd = 1'b1;
    wait_ticks(48);
    check("R3 valid count", nvalid, n0 + 1);
    check("R3 data", last_d, d);
    check("R3 frame_err", last_fe, 1);
    check("R3 brk_flag untouched", brk_flag, 0);
  endtask

  task automatic t_false_start;
    int n0 = nvalid;
    rxd = 1'b0;
    wait_ticks(5);
    rxd = 1'b1;
    wait_ticks(48);
    check("R7 no char on false start", nvalid, n0);
    check("R7 brk_flag", brk_flag, 0);
  endtask

  task automatic t_break;
    int n0 = nvalid;
    send_frame(8'h00, 1'b0, 1'b0, 16);
    wait_ticks(160);
    check("R4 brk_flag set", brk_flag, 1);
    check("R4 frame_err low", frame_err, 0);
    check("R4 no char", nvalid, n0);
    @(negedge clk) clr_status = 1'b1;
    @(negedge clk) clr_status = 1'b0;
    check("R6 cleared by strobe", brk_flag, 0);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    rxd = 1'b0;
    wait_ticks(32);
    check("R5 single high tick ignored", brk_flag, 0);
    rxd = 1'b1;
    wait_ticks(16);
    check("R5 end of break sets flag", brk_flag, 1);
    check("R4 still no char", nvalid, n0);
    wait_ticks(32);
    check("R6 flag sticky", brk_flag, 1);
    @(negedge clk) clr_status = 1'b1;
    @(negedge clk) clr_status = 1'b0;
    wait_ticks(32);
    check("R6 stays clear", brk_flag, 0);
  endtask

  task automatic t_after_break;
    int n0 = nvalid;
    send_frame(8'hC3, 1'b0, 1'b1, 16);
    wait_ticks(32);
    check("R8 char after break", nvalid, n0 + 1);
    check("R8 data", last_d, 8'hC3);
    check("R8 frame_err", last_fe, 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    wait_ticks(20);
    t_good(8'hA5);
    t_good(8'h01);
    t_good(8'hFE);
    t_bad_parity;
    t_frame_err(8'h80, 1'b1);
    t_frame_err(8'h00, 1'b1);
    t_false_start;
    t_break;
    t_after_break;
    done = 1'b1;
    finish_run;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run;
    end
  end
endmodule